// File: doc/BRIEF.md
# Cascaded Two-Stage Pacer Generator

This block produces a periodic one-clock sample-pacer tick by chaining two 16-bit reloading down-counters taken from a small pool of identical counters. The first stage counts the base clock. Each time it reloads it emits a one-clock pulse, and that pulse is the only count enable of the second stage. The second stage's reload pulse is the pacer tick, so the tick period is the product of the two divisors in base-clock cycles.

Software writes the two divisors into pending registers. A commit strobe copies both pending values into the active set at once, so a half-written pair never reaches the counters. A start strobe names the two counters to chain. The block then loads the second stage from the active set in the next cycle and the first stage in the cycle after that. The first stage therefore cannot expire before the second stage holds its count. A stop strobe returns both chained counters to terminal-count mode with no count loaded, and the ticks end. Counters that are not part of the pacer can be loaded one at a time through a direct port. Direct loads aimed at a counter that the pacer owns are refused.

Top module: `cascade_pacer`

## Requirements
- R1: With first-stage divisor D1 and second-stage divisor D2 active, the first tick appears D1*D2+3 cycles after the start strobe is sampled, and later ticks follow every D1*D2 cycles. Each tick lasts one cycle.
- R2: A count value of 0 acts as 65536. A counter loaded directly in terminal-count mode with 0 raises its output exactly 65536 cycles after the load.
- R3: A divisor of 1 is raised to 2 when it is committed. Pending divisors 1 and 3 give a period of 6.
- R4: Staging writes (`stg_sel` 0 = first stage, 1 = second stage) change only the pending set. The active set changes only on `commit`. A commit made while the pacer runs does not alter the running period; the new pair takes effect at the next start.
- R5: On start, the second-stage counter is loaded one cycle before the first-stage counter, and neither counts before both hold their values.
- R6: A stop strobe while the pacer is on clears `pacer_on` and `busy` after one edge. No tick follows, and both chained counter outputs stay low.
- R7: A start naming the same counter twice, naming an index at or above the counter count, or arriving while the pacer is on, is ignored.
- R8: While the pacer is on, `busy` has exactly the two chained counters set. A direct load to a busy counter (or to an out-of-range index) is refused: `dir_rej` pulses for one cycle after it, and the pacer period is unchanged.
- R9: A direct load with `dir_mode`=1 (rate) and value L makes the counter output pulse L cycles after the load and then every L cycles. With `dir_mode`=0 (terminal count), the output rises L cycles after the load and stays high.
- R10: After reset, every counter is idle in terminal-count mode and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_wr | input | 1 | Write pending divisor |
| stg_sel | input | 1 | 0 = first-stage pending, 1 = second-stage pending |
| stg_data | input | CW | Pending divisor value |
| commit | input | 1 | Copy both pending divisors to the active set |
| start_req | input | 1 | Start the pacer on the named counter pair |
| start_sel_a | input | IW | Counter index of the first stage |
| start_sel_b | input | IW | Counter index of the second stage |
| stop_req | input | 1 | Stop the pacer |
| dir_valid | input | 1 | Direct load request |
| dir_idx | input | IW | Counter index for the direct load |
| dir_mode | input | 1 | 0 = terminal count, 1 = rate |
| dir_value | input | CW | Direct load count |
| pacer_tick | output | 1 | One-cycle pacer tick |
| pacer_on | output | 1 | Pacer is loading or running |
| busy | output | NUM_CTR | Counters owned by the pacer |
| ctr_out | output | NUM_CTR | Per-counter output |
| dir_rej | output | 1 | Previous direct load was refused |

## Verification
The bench targets the exact first-tick latency. A design that loaded the first stage before the second would deliver the first tick one cycle early. A design that let the second stage count during loading would deliver it early by a whole first-stage period. It commits a divisor of 1 and checks the period 6, which a design without the minimum rule would turn into period 3 and back-to-back ticks. It also checks the period after a commit made mid-run and after an uncommitted staging write; a single-buffered design would change the period at once. Refused direct loads, a duplicate pair, and the 65536-cycle wait on a zero count catch designs that disturb an owned counter, chain one counter to itself, or treat zero as an immediate expiry.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  typedef enum logic {
    CMODE_TC   = 1'b0,
    CMODE_RATE = 1'b1
  } cmode_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOAD_B,
    SQ_LOAD_A,
    SQ_RUN
  } seq_state_e;

endpackage

// File: rtl/pacer_counter.sv
module pacer_counter
  import pacer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_i,
  input  logic          load_i,
  input  cmode_e        mode_i,
  input  logic [CW-1:0] value_i,
  input  logic          cnt_en_i,
  output logic          out_o
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  cmode_e        mode_q;
  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload_q;
  logic          out_q;
  logic          at_end;

  assign at_end = (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= CMODE_TC;
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      reload_q <= '0;
      out_q    <= 1'b0;
    end else if (stop_i) begin
      mode_q  <= CMODE_TC;
      armed_q <= 1'b0;
      out_q   <= 1'b0;
    end else if (load_i) begin
      mode_q   <= mode_i;
      armed_q  <= 1'b1;
      cnt_q    <= value_i;
      reload_q <= value_i;
      out_q    <= 1'b0;
    end else if (armed_q && cnt_en_i) begin
      if (mode_q == CMODE_RATE) begin
        if (at_end) begin
          cnt_q <= reload_q;
          out_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
          out_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - ONE;
        if (at_end) out_q <= 1'b1;
      end
    end else if (mode_q == CMODE_RATE) begin
      out_q <= 1'b0;
    end
  end

  assign out_o = out_q;

endmodule

// File: rtl/pacer_divbank.sv
module pacer_divbank #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [CW-1:0] data_i,
  input  logic          commit_i,
  output logic [CW-1:0] act_a_o,
  output logic [CW-1:0] act_b_o
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] TWO = {{(CW-2){1'b0}}, 2'b10};

  function automatic logic [CW-1:0] legalize(input logic [CW-1:0] v);
    return (v == ONE) ? TWO : v;
  endfunction

  for (genvar s = 0; s < 2; s++) begin : g_stage
    logic [CW-1:0] pend_q;
    logic [CW-1:0] act_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= '0;
        act_q  <= '0;
      end else begin
        if (wr_i && (sel_i == 1'(s))) pend_q <= data_i;
        if (commit_i) act_q <= legalize(pend_q);
      end
    end
  end

  assign act_a_o = g_stage[0].act_q;
  assign act_b_o = g_stage[1].act_q;

endmodule

// File: rtl/pacer_loadseq.sv
module pacer_loadseq
  import pacer_pkg::*;
#(
  parameter int NUM_CTR = 3,
  parameter int IW      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [IW-1:0]      sel_a_i,
  input  logic [IW-1:0]      sel_b_i,
  input  logic               stop_i,
  output logic               ld_vld_o,
  output logic [IW-1:0]      ld_idx_o,
  output logic               ld_second_o,
  output logic [NUM_CTR-1:0] stop_vec_o,
  output logic [NUM_CTR-1:0] busy_o,
  output logic [NUM_CTR-1:0] second_o,
  output logic               on_o,
  output logic               run_o,
  output logic [IW-1:0]      sel_a_o,
  output logic [IW-1:0]      sel_b_o
);

  localparam logic [IW:0] NCTR = (IW+1)'(NUM_CTR);

  seq_state_e    st_q, st_d;
  logic [IW-1:0] a_q, b_q;
  logic          pair_ok;
  logic          accept;

  assign pair_ok = ({1'b0, sel_a_i} < NCTR) && ({1'b0, sel_b_i} < NCTR) &&
                   (sel_a_i != sel_b_i);
  assign accept  = (st_q == SQ_IDLE) && start_i && pair_ok;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:   if (accept) st_d = SQ_LOAD_B;
      SQ_LOAD_B: st_d = stop_i ? SQ_IDLE : SQ_LOAD_A;
      SQ_LOAD_A: st_d = stop_i ? SQ_IDLE : SQ_RUN;
      SQ_RUN:    if (stop_i) st_d = SQ_IDLE;
      default:   st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
      a_q  <= '0;
      b_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        a_q <= sel_a_i;
        b_q <= sel_b_i;
      end
    end
  end

  assign on_o        = (st_q != SQ_IDLE);
  assign run_o       = (st_q == SQ_RUN);
  assign ld_vld_o    = ((st_q == SQ_LOAD_B) || (st_q == SQ_LOAD_A)) && !stop_i;
  assign ld_second_o = (st_q == SQ_LOAD_B);
  assign ld_idx_o    = ld_second_o ? b_q : a_q;
  assign sel_a_o     = a_q;
  assign sel_b_o     = b_q;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_own
    assign busy_o[i]     = on_o && ((a_q == IW'(i)) || (b_q == IW'(i)));
    assign second_o[i]   = on_o && (b_q == IW'(i));
    assign stop_vec_o[i] = stop_i && busy_o[i];
  end

endmodule

// File: rtl/cascade_pacer.sv
module cascade_pacer
  import pacer_pkg::*;
#(
  parameter int  NUM_CTR = 3,
  parameter int  CW      = 16,
  localparam int IW      = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stg_wr,
  input  logic               stg_sel,
  input  logic [CW-1:0]      stg_data,
  input  logic               commit,
  input  logic               start_req,
  input  logic [IW-1:0]      start_sel_a,
  input  logic [IW-1:0]      start_sel_b,
  input  logic               stop_req,
  input  logic               dir_valid,
  input  logic [IW-1:0]      dir_idx,
  input  logic               dir_mode,
  input  logic [CW-1:0]      dir_value,
  output logic               pacer_tick,
  output logic               pacer_on,
  output logic [NUM_CTR-1:0] busy,
  output logic [NUM_CTR-1:0] ctr_out,
  output logic               dir_rej
);

  localparam logic [IW:0] NCTR = (IW+1)'(NUM_CTR);

  logic [CW-1:0]      act_a, act_b;
  logic               ld_vld, ld_second, run;
  logic [IW-1:0]      ld_idx, sel_a_q, sel_b_q;
  logic [NUM_CTR-1:0] stop_vec, second_vec, cnt_en;
  logic               a_pulse;
  logic               dir_in_range, dir_ok;
  logic               dir_rej_q;

  pacer_divbank #(.CW(CW)) u_divbank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (stg_wr),
    .sel_i    (stg_sel),
    .data_i   (stg_data),
    .commit_i (commit),
    .act_a_o  (act_a),
    .act_b_o  (act_b)
  );

  pacer_loadseq #(.NUM_CTR(NUM_CTR), .IW(IW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_req),
    .sel_a_i     (start_sel_a),
    .sel_b_i     (start_sel_b),
    .stop_i      (stop_req),
    .ld_vld_o    (ld_vld),
    .ld_idx_o    (ld_idx),
    .ld_second_o (ld_second),
    .stop_vec_o  (stop_vec),
    .busy_o      (busy),
    .second_o    (second_vec),
    .on_o        (pacer_on),
    .run_o       (run),
    .sel_a_o     (sel_a_q),
    .sel_b_o     (sel_b_q)
  );

  assign dir_in_range = ({1'b0, dir_idx} < NCTR);
  assign dir_ok       = dir_valid && dir_in_range && !busy[dir_idx];
  assign a_pulse      = ctr_out[sel_a_q];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic          seq_hit, dir_hit;
    cmode_e        ld_mode;
    logic [CW-1:0] ld_val;

    assign seq_hit   = ld_vld && (ld_idx == IW'(i));
    assign dir_hit   = dir_ok && (dir_idx == IW'(i));
    assign ld_mode   = seq_hit ? CMODE_RATE : cmode_e'(dir_mode);
    assign ld_val    = seq_hit ? (ld_second ? act_b : act_a) : dir_value;
    assign cnt_en[i] = second_vec[i] ? (run && a_pulse) : 1'b1;

    pacer_counter #(.CW(CW)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop_i   (stop_vec[i]),
      .load_i   (seq_hit || dir_hit),
      .mode_i   (ld_mode),
      .value_i  (ld_val),
      .cnt_en_i (cnt_en[i]),
      .out_o    (ctr_out[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_rej_q <= 1'b0;
    else        dir_rej_q <= dir_valid && !dir_ok;
  end

  assign dir_rej    = dir_rej_q;
  assign pacer_tick = run && ctr_out[sel_b_q];

endmodule

// File: rtl/cascade_pacer_chk.sv
module cascade_pacer_chk #(
  parameter int NUM_CTR = 3,
  parameter int IW      = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stop_req,
  input logic               dir_valid,
  input logic [IW-1:0]      dir_idx,
  input logic               pacer_tick,
  input logic               pacer_on,
  input logic [NUM_CTR-1:0] busy,
  input logic               dir_rej
);

  localparam logic [IW:0] NCTR = (IW+1)'(NUM_CTR);

  logic idx_ok;
  assign idx_ok = ({1'b0, dir_idx} < NCTR);

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pacer_tick |=> !pacer_tick); // R1

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (pacer_on && stop_req) |=> (!pacer_on && (busy == '0))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pacer_on |-> (!pacer_tick && (busy == '0))); // R6

  AST_TWO_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    pacer_on |-> ($countones(busy) == 2)); // R8

  AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && idx_ok && busy[dir_idx]) |=> dir_rej); // R8

  AST_FREE_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && idx_ok && !busy[dir_idx]) |=> !dir_rej); // R9

  AST_NO_SPURIOUS_REJ: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_valid |=> !dir_rej); // R8

endmodule

bind cascade_pacer cascade_pacer_chk #(.NUM_CTR(NUM_CTR), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_req   (stop_req),
  .dir_valid  (dir_valid),
  .dir_idx    (dir_idx),
  .pacer_tick (pacer_tick),
  .pacer_on   (pacer_on),
  .busy       (busy),
  .dir_rej    (dir_rej)
);

// File: tb/cascade_pacer_tb_top.sv
`timescale 1ns/1ps
module cascade_pacer_tb_top;

  localparam int NUM_CTR = 3;
  localparam int CW      = 16;
  localparam int IW      = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               stg_wr = 1'b0, stg_sel = 1'b0;
  logic [CW-1:0]      stg_data = '0;
  logic               commit = 1'b0;
  logic               start_req = 1'b0;
  logic [IW-1:0]      start_sel_a = '0, start_sel_b = '0;
  logic               stop_req = 1'b0;
  logic               dir_valid = 1'b0;
  logic [IW-1:0]      dir_idx = '0;
  logic               dir_mode = 1'b0;
  logic [CW-1:0]      dir_value = '0;
  logic               pacer_tick, pacer_on, dir_rej;
  logic [NUM_CTR-1:0] busy, ctr_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_n = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cascade_pacer #(.NUM_CTR(NUM_CTR), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .stg_wr(stg_wr), .stg_sel(stg_sel),
    .stg_data(stg_data), .commit(commit), .start_req(start_req),
    .start_sel_a(start_sel_a), .start_sel_b(start_sel_b),
    .stop_req(stop_req), .dir_valid(dir_valid), .dir_idx(dir_idx),
    .dir_mode(dir_mode), .dir_value(dir_value), .pacer_tick(pacer_tick),
    .pacer_on(pacer_on), .busy(busy), .ctr_out(ctr_out), .dir_rej(dir_rej)
  );

  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    if (cyc_n > 195000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_n, 195000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  function automatic longint eff_div(input int v);
    if (v == 0) return 65536;
    if (v == 1) return 2;
    return v;
  endfunction

  function automatic longint exp_period(input int d1, input int d2);
    return eff_div(d1) * eff_div(d2);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic stage(input bit sel, input int v);
    stg_wr = 1'b1; stg_sel = sel; stg_data = CW'(v);
    cyc();
    stg_wr = 1'b0;
  endtask

  task automatic do_commit();
    commit = 1'b1;
    cyc();
    commit = 1'b0;
  endtask

  task automatic start(input int a, input int b);
    start_req = 1'b1; start_sel_a = IW'(a); start_sel_b = IW'(b);
    cyc();
    start_req = 1'b0;
  endtask

  task automatic stop_p();
    stop_req = 1'b1;
    cyc();
    stop_req = 1'b0;
  endtask

  task automatic direct(input int idx, input bit mode, input int v);
    dir_valid = 1'b1; dir_idx = IW'(idx); dir_mode = mode; dir_value = CW'(v);
    cyc();
    dir_valid = 1'b0;
  endtask

  // count negedges after the strobe negedge until the tick (k=1 at that negedge)
  task automatic first_tick(output int k, input int lim);
    k = 1;
    while (k < lim) begin
      cyc(); k++;
      if (pacer_tick) break;
    end
  endtask

  task automatic next_tick(output int k, input int lim);
    k = 0;
    while (k < lim) begin
      cyc(); k++;
      if (pacer_tick) break;
    end
  endtask

  task automatic run_pair(input int a, input int b, input int d1, input int d2,
                          input string req);
    int k;
    longint p;
    p = exp_period(d1, d2);
    start(a, b);
    first_tick(k, int'(p) + 50);
    chk({req, " first tick latency"}, k, p + 4);
    for (int j = 0; j < 2; j++) begin
      next_tick(k, int'(p) + 50);
      chk({req, " tick interval"}, k, p);
    end
  endtask

  initial begin
    int k;
    int a, b, d1, d2;
    void'($urandom(32'd1234));
    repeat (3) cyc();
    // R10: reset state
    chk("R10 outputs in reset", {pacer_tick, pacer_on, busy, ctr_out, dir_rej}, 0);
    rst_n = 1'b1;
    repeat (3) cyc();
    chk("R10 outputs after reset", {pacer_tick, pacer_on, busy, ctr_out, dir_rej}, 0);

    // R1 / R5: directed pair 3 x 4 on counters 0 -> 1
    stage(1'b0, 3); stage(1'b1, 4); do_commit();
    run_pair(0, 1, 3, 4, "R1 R5 3x4");
    chk("R8 busy owned pair", busy, 3'b011);

    // R4: commit while running does not alter the period
    stage(1'b0, 5); stage(1'b1, 5); do_commit();
    next_tick(k, 100);
    next_tick(k, 100);
    chk("R4 period after mid-run commit", k, 12);

    // R8: refused direct load to an owned counter; period unchanged
    dir_valid = 1'b1; dir_idx = 2'd0; dir_mode = 1'b1; dir_value = 16'd2;
    cyc();
    dir_valid = 1'b0;
    chk("R8 dir_rej after owned load", dir_rej, 1);
    cyc();
    chk("R8 dir_rej one cycle", dir_rej, 0);
    next_tick(k, 100);
    next_tick(k, 100);
    chk("R8 period after refused load", k, 12);
    direct(3, 1'b1, 4);
    chk("R8 out-of-range refused", dir_rej, 1);

    // R9: rate mode on free counter 2 while pacer runs
    direct(2, 1'b1, 3);
    chk("R9 free counter accepted", dir_rej, 0);
    k = 1;
    while (k < 50) begin cyc(); k++; if (ctr_out[2]) break; end
    chk("R9 rate first pulse", k, 4);
    k = 0;
    while (k < 50) begin cyc(); k++; if (ctr_out[2]) break; end
    chk("R9 rate interval", k, 3);

    // R7: start while running is ignored
    start(2, 0);
    cyc();
    chk("R7 start while on ignored", busy, 3'b011);

    // R6: stop
    stop_p();
    chk("R6 pacer_on cleared", pacer_on, 0);
    chk("R6 busy cleared", busy, 0);
    k = 0;
    for (int j = 0; j < 60; j++) begin
      cyc();
      if (pacer_tick || ctr_out[0] || ctr_out[1]) k++;
    end
    chk("R6 quiet after stop", k, 0);

    // R4: new active pair (5,5) now used; uncommitted staging write ignored
    stage(1'b0, 7);
    run_pair(0, 1, 5, 5, "R4 committed 5x5");
    stop_p();

    // R3: divisor 1 committed as 2
    stage(1'b0, 1); stage(1'b1, 3); do_commit();
    run_pair(1, 2, 1, 3, "R3 minimum divisor");
    stop_p();

    // R7: same counter twice and out-of-range index
    start(1, 1);
    cyc();
    chk("R7 duplicate pair ignored", pacer_on, 0);
    start(3, 0);
    cyc();
    chk("R7 out-of-range pair ignored", pacer_on, 0);

    // R9: terminal-count mode small value
    direct(2, 1'b0, 5);
    k = 1;
    while (k < 50) begin cyc(); k++; if (ctr_out[2]) break; end
    chk("R9 terminal count rise", k, 6);
    repeat (5) cyc();
    chk("R9 terminal count holds", ctr_out[2], 1);

    // Random pairs and divisors
    for (int it = 0; it < 6; it++) begin
      a  = $urandom % 3;
      b  = (a + 1 + ($urandom % 2)) % 3;
      d1 = 1 + ($urandom % 7);
      d2 = 1 + ($urandom % 7);
      if ($urandom % 2) begin stage(1'b1, d2); stage(1'b0, d1); end
      else begin stage(1'b0, d1); stage(1'b1, d2); end
      do_commit();
      run_pair(a, b, d1, d2, "R1 R3 random");
      chk("R8 random busy", busy, (3'b001 << a) | (3'b001 << b));
      stop_p();
      chk("R6 random stop", pacer_on, 0);
    end

    // R2: zero count means 65536
    direct(2, 1'b0, 0);
    k = 1;
    while (k < 70000) begin cyc(); k++; if (ctr_out[2]) break; end
    chk("R2 zero count length", k, 65537);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule